// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master that software drives through a small register port. Words written to the transmit data register go into a transmit FIFO. A serial engine takes them out one at a time and shifts each one out on MOSI. At the same time it shifts a word in from MISO, or from its own MOSI when loopback is set, and pushes that word into a receive FIFO. Software reads the received words back through the receive data register.

A hold bit in the control register lets software queue a whole burst before any clock runs. Clearing the bit releases the burst. Clock polarity, clock phase and bit order are set in the control register. The serial clock rate comes from a design parameter. The slave-select lines always show the contents of a register that only software writes, so software alone decides when a device is selected.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, ss_n is all ones, sclk is 0, control reads 0x000 and status reads 0x05. Status bit positions: bit0 RX empty, bit1 RX full, bit2 TX empty, bit3 TX full, bit4 always 0.
- R2: The control register is at offset 0x60. Its stored bits are bit0 loopback, bit1 enable, bit2 master, bit3 CPOL, bit4 CPHA, bit7 manual select, bit8 hold and bit9 LSB-first, and each reads back as written. Bits 5 and 6 are actions and always read 0.
- R3: A write to offset 0x70 drives ss_n from the low NSS bits on the next cycle. A 0 bit selects its device.
- R4: While hold (bit8) is set, no transfer starts and queued words stay in the transmit FIFO. Clearing hold while enable and master are set sends the queued words in order.
- R5: TX full (status bit3) is set once the transmit FIFO holds DEPTH words. A write to the transmit data register at 0x68 while the FIFO is full is ignored.
- R6: Writing 1 to control bit5 empties the transmit FIFO. Writing 1 to control bit6 empties the receive FIFO.
- R7: Modes. With CPHA=0, data is sampled on the leading sclk edge; with CPHA=1, on the trailing edge. When idle, sclk rests at CPOL. Bit order is MSB-first unless bit9 is set. Each word sent returns the MISO word in the same bit order.
- R8: With loopback set, the received word equals the sent word and MISO is ignored.
- R9: Each word shifted produces one receive-FIFO push. A word that arrives while the receive FIFO is full is dropped, and rx_overrun pulses for one cycle.
- R10: Reading 0x6C while the receive FIFO is empty returns 0 and pops nothing.
- R11: Each sclk half-period during a word lasts DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at 0x6C) |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Slave-select lines, active low |
| rx_overrun | output | 1 | One-cycle pulse when a received word is dropped |

## Verification
The bench builds the block with its default parameters: 8-bit words, a FIFO depth of 16, DIV=2 and four select lines. A depth of 16 lets the bench fill the transmit FIFO to full, push one write past full, and drive the receive FIFO into overrun, all within a few hundred cycles. DIV=2 keeps a word at 32 cycles, which makes it cheap to run all eight combinations of polarity, phase and bit order with random data. For these runs a bench slave model on the serial pins checks the wire order and the sampling edges.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam logic [7:0] ADDR_CTL  = 8'h60;
    localparam logic [7:0] ADDR_STAT = 8'h64;
    localparam logic [7:0] ADDR_TXD  = 8'h68;
    localparam logic [7:0] ADDR_RXD  = 8'h6C;
    localparam logic [7:0] ADDR_SEL  = 8'h70;

    typedef struct packed {
        logic lsb_first;
        logic hold;
        logic manual;
        logic cpha;
        logic cpol;
        logic master;
        logic enable;
        logic loop;
    } ctl_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t f_d, f_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty   = (f_q.cnt == '0);
    assign full    = (f_q.cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[f_q.rp];

    always_comb begin
        f_d = f_q;
        if (clr) begin
            f_d = '0;
        end else begin
            if (do_push) f_d.wp = (f_q.wp == PW'(DEPTH-1)) ? '0 : f_q.wp + 1'b1;
            if (do_pop)  f_d.rp = (f_q.rp == PW'(DEPTH-1)) ? '0 : f_q.rp + 1'b1;
            f_d.cnt = f_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem_q[f_q.wp] <= din;
    end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int W   = 8,
    parameter int DIV = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] word,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb_first,
    input  logic         loop,
    input  logic         miso,
    output logic         busy,
    output logic         sclk,
    output logic         mosi,
    output logic         done,
    output logic [W-1:0] rx_word
);
    localparam int EW = $clog2(2 * W);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic [DW-1:0] div_cnt;
        logic [EW-1:0] edge_cnt;
        logic [W-1:0]  out_sh;
        logic [W-1:0]  in_sh;
    } sst_t;

    sst_t s_d, s_q;
    logic lead, samp, shift, in_bit;

    assign mosi   = lsb_first ? s_q.out_sh[0] : s_q.out_sh[W-1];
    assign in_bit = loop ? mosi : miso;
    assign lead   = (s_q.edge_cnt[0] == 1'b0);
    assign samp   = (lead != cpha);
    assign shift  = !samp && !(cpha && s_q.edge_cnt == '0);

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!s_q.busy) begin
            s_d.sclk = cpol;
            if (start) begin
                s_d.busy     = 1'b1;
                s_d.out_sh   = word;
                s_d.div_cnt  = '0;
                s_d.edge_cnt = '0;
            end
        end else if (s_q.div_cnt == DW'(DIV - 1)) begin
            s_d.div_cnt  = '0;
            s_d.sclk     = !s_q.sclk;
            s_d.edge_cnt = s_q.edge_cnt + 1'b1;
            if (samp)
                s_d.in_sh = lsb_first ? {in_bit, s_q.in_sh[W-1:1]}
                                      : {s_q.in_sh[W-2:0], in_bit};
            if (shift)
                s_d.out_sh = lsb_first ? (s_q.out_sh >> 1) : (s_q.out_sh << 1);
            if (s_q.edge_cnt == EW'(2 * W - 1)) begin
                s_d.busy = 1'b0;
                done     = 1'b1;
            end
        end else begin
            s_d.div_cnt = s_q.div_cnt + 1'b1;
        end
    end

    assign busy    = s_q.busy;
    assign sclk    = s_q.sclk;
    assign rx_word = s_d.in_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int DIV   = 2,
    parameter int NSS   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [7:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic [NSS-1:0] ss_n,
    output logic           rx_overrun
);
    import spim_pkg::*;

    typedef struct packed {
        ctl_t           ctl;
        logic [NSS-1:0] sel;
    } cst_t;

    cst_t st_d, st_q;
    logic wr_ctl, tx_push, rx_pop, tx_clr, rx_clr, start;
    logic tx_empty, tx_full, rx_empty, rx_full, busy, done;
    logic [W-1:0] tx_word, rx_in, rx_out;

    assign wr_ctl  = reg_wr && (reg_addr == ADDR_CTL);
    assign tx_push = reg_wr && (reg_addr == ADDR_TXD);
    assign rx_pop  = reg_rd && (reg_addr == ADDR_RXD);
    assign tx_clr  = wr_ctl && reg_wdata[5];
    assign rx_clr  = wr_ctl && reg_wdata[6];
    assign start   = st_q.ctl.enable && st_q.ctl.master && !st_q.ctl.hold
                     && !tx_empty && !busy;
    assign rx_overrun = done && rx_full;

    always_comb begin
        st_d = st_q;
        if (wr_ctl) begin
            st_d.ctl.loop      = reg_wdata[0];
            st_d.ctl.enable    = reg_wdata[1];
            st_d.ctl.master    = reg_wdata[2];
            st_d.ctl.cpol      = reg_wdata[3];
            st_d.ctl.cpha      = reg_wdata[4];
            st_d.ctl.manual    = reg_wdata[7];
            st_d.ctl.hold      = reg_wdata[8];
            st_d.ctl.lsb_first = reg_wdata[9];
        end
        if (reg_wr && reg_addr == ADDR_SEL) st_d.sel = reg_wdata[NSS-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTL:  reg_rdata[9:0] = {st_q.ctl.lsb_first, st_q.ctl.hold, st_q.ctl.manual,
                                         2'b00, st_q.ctl.cpha, st_q.ctl.cpol,
                                         st_q.ctl.master, st_q.ctl.enable, st_q.ctl.loop};
            ADDR_STAT: reg_rdata[4:0] = {1'b0, tx_full, tx_empty, rx_full, rx_empty};
            ADDR_RXD:  reg_rdata[W-1:0] = rx_empty ? '0 : rx_out;
            ADDR_SEL:  reg_rdata[NSS-1:0] = st_q.sel;
            default:   reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl <= '0;
            st_q.sel <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ss_n = st_q.sel;

    spim_fifo #(.W(W), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .din(reg_wdata[W-1:0]),
        .pop(start), .dout(tx_word), .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.W(W), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(done), .din(rx_in),
        .pop(rx_pop), .dout(rx_out), .empty(rx_empty), .full(rx_full)
    );

    spim_shift #(.W(W), .DIV(DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .word(tx_word),
        .cpol(st_q.ctl.cpol), .cpha(st_q.ctl.cpha), .lsb_first(st_q.ctl.lsb_first),
        .loop(st_q.ctl.loop), .miso(miso), .busy(busy), .sclk(sclk), .mosi(mosi),
        .done(done), .rx_word(rx_in)
    );
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
    parameter int NSS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_wr,
    input logic           reg_rd,
    input logic [7:0]     reg_addr,
    input logic [31:0]    reg_wdata,
    input logic [31:0]    reg_rdata,
    input logic [NSS-1:0] ss_n,
    input logic           rx_overrun,
    input logic           busy,
    input logic           hold,
    input logic           tx_full,
    input logic           rx_full,
    input logic           rx_empty
);
    assert_sel_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == 8'h70 |=> ss_n == $past(reg_wdata[NSS-1:0]));

    assert_hold_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !busy |=> !busy);

    assert_full_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full && hold && reg_wr && reg_addr == 8'h68 |=> tx_full);

    assert_overrun_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun && !reg_rd && !reg_wr |=> rx_full);

    assert_empty_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == 8'h6C && rx_empty |-> reg_rdata == 32'd0);
endmodule

bind spim_ctrl spim_ctrl_chk #(.NSS(NSS)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ss_n(ss_n), .rx_overrun(rx_overrun),
    .busy(busy), .hold(st_q.ctl.hold), .tx_full(tx_full), .rx_full(rx_full),
    .rx_empty(rx_empty)
);

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
    localparam int W = 8, DEPTH = 16, DIV = 2, NSS = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic sclk, mosi, miso;
    logic [NSS-1:0] ss_n;
    logic rx_overrun;

    int errors = 0, checks = 0, ovr_cnt = 0;

    // bench slave model state
    logic mon_en = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
    int   m_idx = 0, m_edges = 0, cap_n = 0, bad_iv = 0;
    time  last_edge = 0;
    logic [W-1:0] cap_cur = '0;
    logic [W-1:0] cap_w [128];
    logic [W-1:0] miso_w [128];

    always #5 clk = ~clk;

    spim_ctrl #(.W(W), .DEPTH(DEPTH), .DIV(DIV), .NSS(NSS)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .ss_n(ss_n), .rx_overrun(rx_overrun)
    );

    function automatic int wire_pos(input logic lsb, input int idx);
        return lsb ? idx : (W - 1 - idx);
    endfunction

    assign miso = mon_en ? miso_w[cap_n][wire_pos(m_lsb, m_idx)] : 1'b1;

    always @(posedge clk) if (rst_n && rx_overrun) ovr_cnt <= ovr_cnt + 1;

    always @(posedge sclk or negedge sclk) begin
        if (mon_en) begin
            if (m_edges > 0 && ($time - last_edge) != DIV * 10) bad_iv++;
            last_edge = $time;
            if (((sclk != m_cpol) != m_cpha)) begin
                cap_cur[wire_pos(m_lsb, m_idx)] = mosi;
                m_idx++;
                if (m_idx == W) begin
                    cap_w[cap_n] = cap_cur;
                    cap_n++;
                    m_idx = 0;
                end
            end
            m_edges = (m_edges == 2 * W - 1) ? 0 : m_edges + 1;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [W-1:0] fill [DEPTH];
        void'($urandom(32'd4242));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk({28'd0, ss_n}, 32'hF, "R1 ss_n");
        chk({31'd0, sclk}, 32'd0, "R1 sclk");
        rd(8'h64, v); chk(v, 32'h05, "R1 status");
        rd(8'h60, v); chk(v, 32'h000, "R1 control");

        // R3 select register
        wr(8'h70, 32'hA);
        chk({28'd0, ss_n}, 32'hA, "R3 ss_n");
        wr(8'h70, 32'hF);
        chk({28'd0, ss_n}, 32'hF, "R3 ss_n idle");

        // R2 control readback, action bits read 0
        wr(8'h60, 32'h3FF); rd(8'h60, v); chk(v, 32'h39F, "R2 ctl all");
        wr(8'h60, 32'h001); rd(8'h60, v); chk(v, 32'h001, "R2 loop bit");

        // R10 empty receive read
        rd(8'h6C, v); chk(v, 32'd0, "R10 empty read");
        rd(8'h64, v); chk(v, 32'h05, "R10 no pop");

        // R4 hold, R8 loopback
        wr(8'h60, 32'h107);
        wr(8'h68, 32'hA5); wr(8'h68, 32'h3C); wr(8'h68, 32'h01);
        idle(200);
        rd(8'h64, v); chk(v, 32'h01, "R4 held queue");
        wr(8'h60, 32'h007);
        idle(300);
        rd(8'h64, v); chk(v, 32'h05 & 32'h04, "R4 drained");
        rd(8'h6C, v); chk(v, 32'hA5, "R8 loop w0");
        rd(8'h6C, v); chk(v, 32'h3C, "R8 loop w1");
        rd(8'h6C, v); chk(v, 32'h01, "R8 loop w2");

        // R5 fill to full, write past full ignored
        wr(8'h60, 32'h107);
        for (int i = 0; i < DEPTH; i++) begin
            fill[i] = W'($urandom);
            if (i == DEPTH - 1) begin
                rd(8'h64, v); chk(v, 32'h01, "R5 not full at DEPTH-1");
            end
            wr(8'h68, {24'd0, fill[i]});
        end
        rd(8'h64, v); chk(v, 32'h09, "R5 full");
        wr(8'h68, 32'hEE);
        wr(8'h60, 32'h007);
        idle(DEPTH * 2 * W * DIV + 200);
        rd(8'h64, v); chk(v, 32'h06, "R9 rx full");
        // R9 overrun: one extra word dropped
        wr(8'h68, 32'h77);
        idle(200);
        chk(ovr_cnt, 32'd1, "R9 overrun pulse");
        rd(8'h64, v); chk(v, 32'h06, "R9 still full");
        for (int i = 0; i < DEPTH; i++) begin
            rd(8'h6C, v); chk(v, {24'd0, fill[i]}, "R5 R9 order kept");
        end
        rd(8'h64, v); chk(v, 32'h05, "R9 drained");

        // R6 FIFO resets
        wr(8'h60, 32'h107);
        for (int i = 0; i < 4; i++) wr(8'h68, 32'h10 + i);
        rd(8'h64, v); chk(v, 32'h01, "R6 tx loaded");
        wr(8'h60, 32'h127);
        rd(8'h64, v); chk(v, 32'h05, "R6 tx cleared");
        wr(8'h60, 32'h007);
        wr(8'h68, 32'h55); wr(8'h68, 32'h66);
        idle(200);
        rd(8'h64, v); chk(v, 32'h04, "R6 rx loaded");
        wr(8'h60, 32'h047);
        rd(8'h64, v); chk(v, 32'h05, "R6 rx cleared");

        // R7 every mode with random data against the slave model
        for (int mode = 0; mode < 8; mode++) begin
            logic [31:0] cfg;
            logic [W-1:0] txw [4];
            int base;
            cfg = 32'h106 | (32'(mode & 1) << 3) | (32'((mode >> 1) & 1) << 4)
                          | (32'((mode >> 2) & 1) << 9);
            mon_en = 1'b0;
            wr(8'h60, cfg);
            wr(8'h70, 32'hE);
            idle(4);
            chk({31'd0, sclk}, {31'd0, cfg[3]}, "R7 idle level");
            m_cpol = cfg[3]; m_cpha = cfg[4]; m_lsb = cfg[9];
            m_idx = 0; m_edges = 0;
            base = cap_n;
            for (int k = 0; k < 4; k++) begin
                txw[k] = W'($urandom);
                miso_w[base + k] = W'($urandom);
                wr(8'h68, {24'd0, txw[k]});
            end
            mon_en = 1'b1;
            wr(8'h60, cfg & ~32'h100);
            idle(4 * 2 * W * DIV + 100);
            mon_en = 1'b0;
            chk(cap_n - base, 32'd4, "R7 words on wire");
            for (int k = 0; k < 4; k++) begin
                chk({24'd0, cap_w[base + k]}, {24'd0, txw[k]}, "R7 mosi word");
                rd(8'h6C, v); chk(v, {24'd0, miso_w[base + k]}, "R7 miso word");
            end
            wr(8'h70, 32'hF);
        end
        chk(bad_iv, 32'd0, "R11 half period");
        chk(ovr_cnt, 32'd1, "R9 no stray overrun");

        finish_run();
    end
endmodule